// File: doc/BRIEF.md
# CRT Controller Host Register Access Unit

This block is the host-facing side of a CRT display controller. A host first writes a register index, then writes or reads the selected register through the same data port. Sixteen configuration registers (indices 0 to 15) drive the timing core through one flat vector. Each register keeps only the bits its field uses. A separate strobe reads a status byte.

The unit also keeps a light pen latch. On the rising edge of the light pen strobe it stores the memory address that the timing core is presenting, and it raises a status flag. The flag stays up until the host reads one of the two latch registers. A second status flag follows the vertical blanking indication from the timing core.

A `CRTC_TYPE` parameter selects the read-back rules. Type 0 returns the start-address pair and has no readable status. Type 1 hides the start-address pair, exposes the status byte, and answers index 31 with all ones. All reads are registered: `rd_data` changes on the clock edge where the read strobe is sampled and holds its value until the next read.

Top module: `crtc_host_regs`

## Requirements
- R1: After a synchronous active-low reset, `rd_data`, every configuration register, the index, the light pen latch and both status flags are 0.
- R2: A data write stores `host_wdata` ANDed with the field mask into the configuration register selected by the current index. The new value appears on `cfg_flat` (register i at bits i*8+7..i*8) one cycle later. Field widths for indices 0 to 15 are 8,8,8,8,7,5,7,7,8,5,7,5,6,8,6,8 bits, kept in the low bits.
- R3: A data write while the index is 16 to 31 changes neither `cfg_flat` nor the light pen latch.
- R4: A data read of index 14 or 15 returns the stored value. Index 12 or 13 returns the stored value on type 0 and 0 on type 1. Indices 0 to 11 return 0.
- R5: On each rising edge of `lpen_stb` the unit captures `cur_ma`. Index 16 then reads the capture's upper bits (ma[13:8], with the upper 2 bits 0) and index 17 reads ma[7:0]. Keeping the strobe high does not capture again.
- R6: Status bit 6 is set by a light pen rising edge and cleared by a data read of index 16 or 17. If a rising edge arrives in the same cycle as such a read, the bit stays set.
- R7: Status bit 5 equals `vblank` as sampled at the previous clock edge. It is high while the vertical count is at or above the displayed-rows setting, and it drops when a new frame starts.
- R8: Data reads of indices 18 to 30 return 0. Index 31 returns 0xFF on type 1 and 0 on type 0. Writes to index 31 have no effect.
- R9: On type 1 a status read returns bit 6 and bit 5, with every other bit 0. On type 0 a status read returns 0.
- R10: When neither read strobe is high, `rd_data` holds its previous value. If both strobes are high, the data read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | 1 | Load the register index from `host_wdata[4:0]` |
| data_we | input | 1 | Write `host_wdata` to the selected register |
| data_re | input | 1 | Read the selected register into `rd_data` |
| stat_re | input | 1 | Read the status byte into `rd_data` |
| host_wdata | input | 8 | Host write data (index or register value) |
| lpen_stb | input | 1 | Light pen strobe, level, synchronous |
| cur_ma | input | 14 | Current memory address from the timing core |
| vblank | input | 1 | Vertical blanking flag from the timing core |
| rd_data | output | 8 | Registered read data |
| cfg_flat | output | 128 | Configuration registers 0 to 15, 8 bits each |

## Verification
The bound checker covers the rules that hold on every cycle:
- the light pen flag rises after a strobe edge and falls after a clearing read with no edge;
- the blanking flag tracks its input with one cycle of delay;
- the latch holds its value between strobe edges;
- `rd_data` is stable when no read is issued;
- writes to indices 16 and up leave the configuration vector untouched;
- indices 18 to 30 read as zero.

The type-dependent read-back of the start pair, index 31 and the status byte is shown only by the bench. So are the exact captured address, the field masking, and the same-cycle collision of a strobe edge with a clearing read. The bench runs a type 0 and a type 1 instance side by side against its reference model.

// File: rtl/crtc_host_pkg.sv
// Package: shared register indices, status bit positions and field masks
// for the CRT controller host register access unit.
// Assumes 8-bit register fields; masks are given for indices 0..15.
package crtc_host_pkg;

    localparam int IDX_START_HI = 12;
    localparam int IDX_START_LO = 13;
    localparam int IDX_CUR_HI   = 14;
    localparam int IDX_CUR_LO   = 15;
    localparam int IDX_LPEN_HI  = 16;
    localparam int IDX_LPEN_LO  = 17;
    localparam int IDX_DUMMY    = 31;

    localparam int ST_LP_BIT    = 6;
    localparam int ST_VB_BIT    = 5;

    // Field mask for a configuration register; bits outside the field read 0.
    function automatic logic [7:0] cfg_mask(input int idx);
        case (idx)
            4, 6, 7, 10: cfg_mask = 8'h7F;
            5, 9, 11:    cfg_mask = 8'h1F;
            12, 14:      cfg_mask = 8'h3F;
            default:     cfg_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/crtc_cfg_bank.sv
// Module: index register and configuration register bank.
// Holds the host-selected index and NCFG masked configuration registers.
// Assumes NCFG <= 2**ADDR_W; indices at or above NCFG have no storage,
// so writes to them are dropped.
module crtc_cfg_bank
    import crtc_host_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int NCFG   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_we,
    input  logic                     data_we,
    input  logic [DATA_W-1:0]        wdata,
    output logic [ADDR_W-1:0]        sel_idx,
    output logic [NCFG*DATA_W-1:0]   cfg_flat
);

    // Load the register index from the host data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_idx <= '0;
        else if (sel_we) sel_idx <= wdata[ADDR_W-1:0];
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = DATA_W'(cfg_mask(g));
        logic [DATA_W-1:0] slot;

        // Store masked host data when this register is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot <= '0;
            else if (data_we && (sel_idx == ADDR_W'(g)))
                slot <= wdata & MASK;
        end

        assign cfg_flat[g*DATA_W +: DATA_W] = slot;
    end

endmodule

// File: rtl/crtc_lpen_status.sv
// Module: light pen address latch and status flags.
// Captures the memory address on a strobe rising edge and keeps the
// light pen flag (set on edge, cleared by clr_req, edge wins) and the
// blanking flag (registered copy of vblank).
// Assumes lpen_stb is already synchronous to clk.
module crtc_lpen_status #(
    parameter int MA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lpen_stb,
    input  logic [MA_W-1:0] cur_ma,
    input  logic            vblank,
    input  logic            clr_req,
    output logic [MA_W-1:0] lpen_addr,
    output logic            lp_flag,
    output logic            vb_flag
);

    logic stb_q;
    logic stb_rise;

    assign stb_rise = lpen_stb && !stb_q;

    // Delay the strobe one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= lpen_stb;
    end

    // Capture the memory address on a strobe rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        lpen_addr <= '0;
        else if (stb_rise) lpen_addr <= cur_ma;
    end

    // Light pen flag: the edge sets it with priority over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)        lp_flag <= 1'b0;
        else if (stb_rise) lp_flag <= 1'b1;
        else if (clr_req)  lp_flag <= 1'b0;
    end

    // Blanking flag follows the timing core's vblank flag.
    always_ff @(posedge clk) begin
        if (!rst_n) vb_flag <= 1'b0;
        else        vb_flag <= vblank;
    end

endmodule

// File: rtl/crtc_rd_mux.sv
// Module: read-back selection and registered read data.
// Chooses the register or status value by index and controller type,
// and registers it when a read strobe is high; a data read outranks
// a status read.
// Assumes MA_W <= 2*DATA_W.
module crtc_rd_mux
    import crtc_host_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8,
    parameter int MA_W      = 14,
    parameter int CRTC_TYPE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_re,
    input  logic              stat_re,
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] start_hi,
    input  logic [DATA_W-1:0] start_lo,
    input  logic [DATA_W-1:0] cur_hi,
    input  logic [DATA_W-1:0] cur_lo,
    input  logic [MA_W-1:0]   lpen_addr,
    input  logic              lp_flag,
    input  logic              vb_flag,
    output logic [DATA_W-1:0] rd_data
);

    localparam bit TYPE1 = (CRTC_TYPE == 1);
    localparam int PAD_W = 2*DATA_W - MA_W;

    logic [2*DATA_W-1:0] lp_wide;
    logic [DATA_W-1:0]   reg_val;
    logic [DATA_W-1:0]   stat_val;

    assign lp_wide = {{PAD_W{1'b0}}, lpen_addr};

    // Select the read-back value for the current index and controller type.
    always_comb begin
        reg_val = '0;
        case (idx)
            ADDR_W'(IDX_START_HI): reg_val = TYPE1 ? '0 : start_hi;
            ADDR_W'(IDX_START_LO): reg_val = TYPE1 ? '0 : start_lo;
            ADDR_W'(IDX_CUR_HI):   reg_val = cur_hi;
            ADDR_W'(IDX_CUR_LO):   reg_val = cur_lo;
            ADDR_W'(IDX_LPEN_HI):  reg_val = lp_wide[2*DATA_W-1:DATA_W];
            ADDR_W'(IDX_LPEN_LO):  reg_val = lp_wide[DATA_W-1:0];
            ADDR_W'(IDX_DUMMY):    reg_val = TYPE1 ? '1 : '0;
            default:               reg_val = '0;
        endcase
    end

    // Build the status byte; only type 1 exposes its flags.
    always_comb begin
        stat_val = '0;
        stat_val[ST_LP_BIT] = TYPE1 ? lp_flag : 1'b0;
        stat_val[ST_VB_BIT] = TYPE1 ? vb_flag : 1'b0;
    end

    // Register the read data; hold it when no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (data_re) rd_data <= reg_val;
        else if (stat_re) rd_data <= stat_val;
    end

endmodule

// File: rtl/crtc_host_regs.sv
// Module: top of the CRT controller host register access unit.
// Connects the index and configuration bank, the light pen and status
// block and the read-back mux. Index 16 or 17 on a data read clears the
// light pen flag.
// Assumes every host strobe is synchronous to clk.
module crtc_host_regs
    import crtc_host_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8,
    parameter int MA_W      = 14,
    parameter int NCFG      = 16,
    parameter int CRTC_TYPE = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_we,
    input  logic                   data_we,
    input  logic                   data_re,
    input  logic                   stat_re,
    input  logic [DATA_W-1:0]      host_wdata,
    input  logic                   lpen_stb,
    input  logic [MA_W-1:0]        cur_ma,
    input  logic                   vblank,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NCFG*DATA_W-1:0] cfg_flat
);

    logic [ADDR_W-1:0] sel_idx;
    logic [MA_W-1:0]   lpen_addr;
    logic              lp_flag;
    logic              vb_flag;
    logic              clr_req;

    // A data read of either latch register clears the light pen flag.
    assign clr_req = data_re && ((sel_idx == ADDR_W'(IDX_LPEN_HI)) ||
                                 (sel_idx == ADDR_W'(IDX_LPEN_LO)));

    crtc_cfg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCFG(NCFG)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
        .wdata(host_wdata), .sel_idx(sel_idx), .cfg_flat(cfg_flat)
    );

    crtc_lpen_status #(
        .MA_W(MA_W)
    ) u_lpen (
        .clk(clk), .rst_n(rst_n), .lpen_stb(lpen_stb), .cur_ma(cur_ma),
        .vblank(vblank), .clr_req(clr_req), .lpen_addr(lpen_addr),
        .lp_flag(lp_flag), .vb_flag(vb_flag)
    );

    crtc_rd_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MA_W(MA_W), .CRTC_TYPE(CRTC_TYPE)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .data_re(data_re), .stat_re(stat_re),
        .idx(sel_idx),
        .start_hi(cfg_flat[IDX_START_HI*DATA_W +: DATA_W]),
        .start_lo(cfg_flat[IDX_START_LO*DATA_W +: DATA_W]),
        .cur_hi(cfg_flat[IDX_CUR_HI*DATA_W +: DATA_W]),
        .cur_lo(cfg_flat[IDX_CUR_LO*DATA_W +: DATA_W]),
        .lpen_addr(lpen_addr), .lp_flag(lp_flag), .vb_flag(vb_flag),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/crtc_host_regs_chk.sv
// Module: assertion checker for crtc_host_regs, attached with bind.
// Observes ports and the internal index, latch and flags.
module crtc_host_regs_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int MA_W   = 14,
    parameter int NCFG   = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   data_we,
    input logic                   data_re,
    input logic                   stat_re,
    input logic                   lpen_stb,
    input logic                   vblank,
    input logic [ADDR_W-1:0]      sel_idx,
    input logic [NCFG*DATA_W-1:0] cfg_flat,
    input logic [DATA_W-1:0]      rd_data,
    input logic [MA_W-1:0]        lpen_addr,
    input logic                   lp_flag,
    input logic                   vb_flag
);

    logic prev_stb;
    logic edge_seen;
    logic lp_sel;

    // Track the strobe on its own to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_stb <= 1'b0;
        else        prev_stb <= lpen_stb;
    end

    assign edge_seen = lpen_stb && !prev_stb;
    assign lp_sel    = (sel_idx == ADDR_W'(16)) || (sel_idx == ADDR_W'(17));

    // R6: a strobe edge raises the light pen flag
    a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> lp_flag);

    // R6: a clearing read with no edge drops the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && lp_sel && !edge_seen) |=> !lp_flag);

    // R5: the latch only changes on a strobe edge
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_seen |=> $stable(lpen_addr));

    // R7: the blanking flag follows vblank by one cycle
    a_r7_vb_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (vb_flag == $past(vblank)));

    // R3: writes above the configuration range leave it unchanged
    a_r3_high_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && (sel_idx >= ADDR_W'(NCFG))) |=> $stable(cfg_flat));

    // R10: read data holds without a read strobe
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_re && !stat_re) |=> $stable(rd_data));

    // R8: indices 18..30 read zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && (sel_idx >= ADDR_W'(18)) && (sel_idx <= ADDR_W'(30)))
        |=> (rd_data == '0));

endmodule

bind crtc_host_regs crtc_host_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MA_W(MA_W), .NCFG(NCFG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_re(data_re),
    .stat_re(stat_re), .lpen_stb(lpen_stb), .vblank(vblank),
    .sel_idx(sel_idx), .cfg_flat(cfg_flat), .rd_data(rd_data),
    .lpen_addr(lpen_addr), .lp_flag(lp_flag), .vb_flag(vb_flag)
);

// File: tb/tb_crtc_host_regs.sv
`timescale 1ns/1ps
module tb_crtc_host_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_we = 1'b0, data_we = 1'b0, data_re = 1'b0, stat_re = 1'b0;
    logic [7:0]   host_wdata = '0;
    logic         lpen_stb = 1'b0;
    logic [13:0]  cur_ma = '0;
    logic         vblank = 1'b0;
    logic [7:0]   rd1, rd0;
    logic [127:0] cfg1, cfg0;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    crtc_host_regs #(.CRTC_TYPE(1)) dut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
        .data_re(data_re), .stat_re(stat_re), .host_wdata(host_wdata),
        .lpen_stb(lpen_stb), .cur_ma(cur_ma), .vblank(vblank),
        .rd_data(rd1), .cfg_flat(cfg1));

    crtc_host_regs #(.CRTC_TYPE(0)) dut_t0 (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
        .data_re(data_re), .stat_re(stat_re), .host_wdata(host_wdata),
        .lpen_stb(lpen_stb), .cur_ma(cur_ma), .vblank(vblank),
        .rd_data(rd0), .cfg_flat(cfg0));

    // ---------------- reference model ----------------
    int       m_regs[16];
    int       m_idx, m_lp;
    bit       m_f6, m_f5, m_lq, started;
    logic [7:0] m_rd1, m_rd0;

    function automatic int bmask(int i);
        int w[16] = '{8,8,8,8,7,5,7,7,8,5,7,5,6,8,6,8};
        return (1 << w[i]) - 1;
    endfunction

    function automatic logic [7:0] mval(bit t1, int i);
        if (i == 12 || i == 13) return t1 ? 8'h00 : 8'(m_regs[i]);
        if (i == 14 || i == 15) return 8'(m_regs[i]);
        if (i == 16) return 8'((m_lp >> 8) & 8'hFF);
        if (i == 17) return 8'(m_lp & 8'hFF);
        if (i == 31) return t1 ? 8'hFF : 8'h00;
        return 8'h00;
    endfunction

    function automatic logic [127:0] mcfg();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(m_regs[i]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_regs[i] = 0;
            m_idx = 0; m_lp = 0; m_f6 = 0; m_f5 = 0; m_lq = 0;
            m_rd1 = 0; m_rd0 = 0;
        end else begin
            bit rise;
            rise = lpen_stb && !m_lq;
            if (data_re) begin
                m_rd1 = mval(1'b1, m_idx); m_rd0 = mval(1'b0, m_idx);
            end else if (stat_re) begin
                m_rd1 = {1'b0, m_f6, m_f5, 5'b0}; m_rd0 = 8'h00;
            end
            if (rise) begin m_f6 = 1; m_lp = int'(cur_ma); end
            else if (data_re && (m_idx == 16 || m_idx == 17)) m_f6 = 0;
            m_f5 = vblank;
            if (data_we && m_idx < 16) m_regs[m_idx] = int'(host_wdata) & bmask(m_idx);
            if (sel_we) m_idx = int'(host_wdata[4:0]);
            m_lq = lpen_stb;
        end
        started = 1;
    end

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output of both instances against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "type1 rd_data", 128'(rd1), 128'(m_rd1));
            chk(cur_req, "type0 rd_data", 128'(rd0), 128'(m_rd0));
            chk(cur_req, "type1 cfg_flat", cfg1, mcfg());
            chk(cur_req, "type0 cfg_flat", cfg0, mcfg());
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(); @(negedge clk); endtask

    task automatic sel(int i);
        sel_we = 1; host_wdata = 8'(i); cyc(); sel_we = 0;
    endtask

    task automatic wr_reg(int i, int v);
        sel(i); data_we = 1; host_wdata = 8'(v); cyc(); data_we = 0;
    endtask

    task automatic rd_reg(int i);
        sel(i); data_re = 1; cyc(); data_re = 0;
    endtask

    task automatic rd_stat();
        stat_re = 1; cyc(); stat_re = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] snap;
        repeat (3) cyc();
        cur_req = "R1";
        chk("R1", "reset rd type1", 128'(rd1), 128'h0);
        chk("R1", "reset rd type0", 128'(rd0), 128'h0);
        chk("R1", "reset cfg", cfg1, 128'h0);
        rst_n = 1; cyc();

        cur_req = "R2";
        for (int i = 0; i < 16; i++) wr_reg(i, 8'hFF);
        chk("R2", "reg4 masked", 128'(cfg1[4*8 +: 8]), 128'h7F);
        chk("R2", "reg9 masked", 128'(cfg1[9*8 +: 8]), 128'h1F);
        chk("R2", "reg12 masked", 128'(cfg0[12*8 +: 8]), 128'h3F);
        for (int i = 0; i < 16; i++) wr_reg(i, (i * 37 + 11) & 8'hFF);

        cur_req = "R4";
        wr_reg(14, 8'h2B); wr_reg(15, 8'hC4); wr_reg(12, 8'h35); wr_reg(13, 8'h9A);
        rd_reg(14); chk("R4", "idx14", 128'(rd1), 128'h2B);
        rd_reg(15); chk("R4", "idx15", 128'(rd0), 128'hC4);
        rd_reg(12); chk("R4", "idx12 type0", 128'(rd0), 128'h35);
                    chk("R4", "idx12 type1", 128'(rd1), 128'h00);
        rd_reg(13); chk("R4", "idx13 type0", 128'(rd0), 128'h9A);
        rd_reg(3);  chk("R4", "idx3", 128'(rd1), 128'h00);
        for (int i = 0; i < 16; i++) rd_reg(i);

        cur_req = "R3";
        snap = cfg1;
        wr_reg(16, 8'h55); wr_reg(17, 8'hAA); wr_reg(31, 8'h12); wr_reg(25, 8'h77);
        chk("R3", "cfg unchanged", cfg1, snap);
        rd_reg(16); chk("R3", "latch hi unchanged", 128'(rd1), 128'h00);
        rd_reg(17); chk("R3", "latch lo unchanged", 128'(rd0), 128'h00);

        cur_req = "R5";
        cur_ma = 14'h2A5C; lpen_stb = 1; cyc();
        cur_ma = 14'h1111; cyc(); cyc(); lpen_stb = 0; cyc();
        cur_req = "R9";
        rd_stat(); chk("R9", "type0 status", 128'(rd0), 128'h00);
        chk("R6", "status after edge", 128'(rd1), 128'h40);
        cur_req = "R5";
        rd_reg(16); chk("R5", "latch hi", 128'(rd1), 128'h2A);
        rd_reg(17); chk("R5", "latch lo", 128'(rd0), 128'h5C);

        cur_req = "R6";
        rd_stat(); chk("R6", "cleared by read", 128'(rd1), 128'h00);
        sel(16);
        cur_ma = 14'h0F0F; data_re = 1; lpen_stb = 1; cyc();
        data_re = 0; lpen_stb = 0; cyc();
        rd_stat(); chk("R6", "edge beats clear", 128'(rd1), 128'h40);

        cur_req = "R7";
        vblank = 1; cyc();
        rd_stat(); chk("R7", "vblank set", 128'(rd1), 128'h60);
        vblank = 0; cyc();
        rd_stat(); chk("R7", "frame start", 128'(rd1), 128'h40);
        for (int i = 0; i < 6; i++) begin vblank = i[0]; stat_re = 1; cyc(); end
        stat_re = 0; vblank = 0;

        cur_req = "R8";
        rd_reg(20); chk("R8", "idx20", 128'(rd1), 128'h00);
        rd_reg(31); chk("R8", "idx31 type1", 128'(rd1), 128'hFF);
                    chk("R8", "idx31 type0", 128'(rd0), 128'h00);
        for (int i = 18; i < 32; i++) rd_reg(i);

        cur_req = "R10";
        rd_reg(15);
        repeat (4) cyc();
        chk("R10", "hold", 128'(rd1), 128'hC4);
        sel(14); data_re = 1; stat_re = 1; cyc(); data_re = 0; stat_re = 0;
        chk("R10", "data read wins", 128'(rd1), 128'h2B);
        cyc();
        finish_run();
    end

endmodule